// File: doc/BRIEF.md
# Reset Boot Source Selector

This block runs once after every reset and decides where the processor starts: in the on-chip boot ROM or in the application image held in flash. A strap configuration can name one general-purpose input pin, out of eight banks of eight, together with the level that requests ROM boot. A separate bypass flag turns that pin test off.

When the pin test is off or does not request ROM boot, the block reads the reset-vector word from flash. A word that is still erased, with every bit set, also selects ROM boot. Any other value is taken as the application's entry point, and the block then makes one more read for the initial stack pointer. The result is a ROM-remap flag plus initial stack pointer and program counter values. A single-cycle done strobe marks when they are valid. They stay held until the next reset.

Top module: `boot_src_sel`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `boot_done`, `fl_req` and `rom_map` are 0, and `init_sp` and `init_pc` are 0.
- R2: If `cfg_bypass` is 0 and the selected pin equals `cfg_level`, the block selects ROM boot with `rom_map`=1 and `init_sp`=`init_pc`=0, and it makes no flash read.
- R3: The selected pin is `gpio_in[cfg_bank*8 + cfg_bit]`, where `cfg_bank` (3 bits, value 0..7) picks the bank and `cfg_bit` (3 bits) picks the pin inside that bank. No other GPIO line affects the decision.
- R4: If `cfg_bypass` is 1, the pin level is ignored and the first flash read is at address 0x00000004.
- R5: If `cfg_bypass` is 0 and the selected pin differs from `cfg_level`, the first flash read is at address 0x00000004.
- R6: If the word read at 0x00000004 is 0xFFFFFFFF, the block selects ROM boot with `init_sp`=`init_pc`=0 and makes no further read.
- R7: Otherwise the block makes exactly one more read, at 0x00000000. It finishes with `rom_map`=0, `init_pc` equal to the word at 0x4 and `init_sp` equal to the word at 0x0.
- R8: Once raised, `fl_req` stays high with a stable `fl_addr` until a cycle in which `fl_valid` is high. Any number of wait cycles is accepted.
- R9: `boot_done` is high for exactly one cycle per reset. After that, `rom_map`, `init_sp` and `init_pc` hold their values and `fl_req` stays low until the next reset, whatever the GPIO inputs do.
- R10: Each GPIO input passes through a two-stage synchroniser. In the pin-match case, `boot_done` is therefore high in the cycle after the third rising edge that follows reset release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bypass | input | 1 | 1: skip the pin test |
| cfg_bank | input | 3 | Bank of the strap pin |
| cfg_bit | input | 3 | Pin within the bank |
| cfg_level | input | 1 | Pin level that requests ROM boot |
| gpio_in | input | 64 | Raw GPIO levels, bank-major |
| fl_req | output | 1 | Flash read request |
| fl_addr | output | 32 | Flash word address |
| fl_valid | input | 1 | Read data valid, one cycle per request |
| fl_rdata | input | 32 | Flash read data |
| rom_map | output | 1 | 1: ROM mapped at address 0 |
| init_sp | output | 32 | Initial stack pointer |
| init_pc | output | 32 | Initial program counter |
| boot_done | output | 1 | One-cycle decision strobe |

## Verification
The assertions assume that the strap configuration stays fixed between reset release and the done strobe. They also assume that `fl_valid` pulses for one cycle only while `fl_req` is high, and that the strap pin holds its level through the synchroniser window. The stimulus sets the configuration and GPIO levels before it releases reset and keeps them there until the decision. A responder raises valid for a single cycle after a chosen delay and drops it on the next cycle. The GPIO inputs are changed only after the done strobe, to show that they have no further effect.

// File: rtl/boot_sel_pkg.sv
package boot_sel_pkg;

    parameter int unsigned BANKS         = 8;
    parameter int unsigned PINS_PER_BANK = 8;
    parameter int unsigned WORD_W        = 32;
    parameter int unsigned SYNC_STAGES   = 2;

    localparam int unsigned GPIO_W  = BANKS * PINS_PER_BANK;
    localparam int unsigned BANK_W  = $clog2(BANKS);
    localparam int unsigned BIT_W   = $clog2(PINS_PER_BANK);
    localparam int unsigned INDEX_W = $clog2(GPIO_W);
    localparam int unsigned CNT_W   = $clog2(SYNC_STAGES) + 1;

    localparam logic [WORD_W-1:0] VECTOR_ADDR = WORD_W'(4);
    localparam logic [WORD_W-1:0] STACK_ADDR  = WORD_W'(0);
    localparam logic [WORD_W-1:0] BLANK_WORD  = {WORD_W{1'b1}};

    typedef enum logic [2:0] {
        ST_SETTLE,
        ST_DECIDE,
        ST_FETCH_PC,
        ST_FETCH_SP,
        ST_HOLD
    } boot_state_t;

    typedef struct packed {
        logic              bypass;
        logic [BANK_W-1:0] bank;
        logic [BIT_W-1:0]  bit_sel;
        logic              level;
    } strap_cfg_t;

    typedef struct packed {
        logic              rom;
        logic [WORD_W-1:0] sp;
        logic [WORD_W-1:0] pc;
    } boot_result_t;

    function automatic logic [INDEX_W-1:0] pin_index(
        input logic [BANK_W-1:0] bank,
        input logic [BIT_W-1:0]  bit_sel
    );
        int unsigned idx;
        idx = int'(bank) * PINS_PER_BANK + int'(bit_sel);
        return INDEX_W'(idx);
    endfunction

endpackage

// File: rtl/boot_gpio_sync.sv
module boot_gpio_sync #(
    parameter int unsigned WIDTH  = 64,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= d;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= chain[s-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/boot_pin_match.sv
module boot_pin_match
    import boot_sel_pkg::*;
(
    input  logic [GPIO_W-1:0] gpio_sync,
    input  strap_cfg_t        cfg,
    output logic              match
);
    logic [INDEX_W-1:0] idx;
    logic               level_now;

    always_comb begin
        idx       = pin_index(cfg.bank, cfg.bit_sel);
        level_now = gpio_sync[idx];
        match     = (level_now == cfg.level);
    end
endmodule

// File: rtl/boot_fsm.sv
module boot_fsm
    import boot_sel_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  strap_cfg_t        cfg,
    input  logic              pin_match,
    output logic              fl_req,
    output logic [WORD_W-1:0] fl_addr,
    input  logic              fl_valid,
    input  logic [WORD_W-1:0] fl_rdata,
    output boot_result_t      result,
    output logic              done
);
    boot_state_t      state, nxt;
    logic [CNT_W-1:0] settle_cnt;
    boot_result_t     res_q;
    logic             done_q;
    logic             blank;

    assign blank = (fl_rdata == BLANK_WORD);

    always_comb begin
        nxt     = state;
        fl_req  = 1'b0;
        fl_addr = VECTOR_ADDR;
        unique case (state)
            ST_SETTLE: begin
                if (settle_cnt == CNT_W'(SYNC_STAGES - 1)) nxt = ST_DECIDE;
            end
            ST_DECIDE: begin
                if (!cfg.bypass && pin_match) nxt = ST_HOLD;
                else                          nxt = ST_FETCH_PC;
            end
            ST_FETCH_PC: begin
                fl_req  = 1'b1;
                fl_addr = VECTOR_ADDR;
                if (fl_valid) nxt = blank ? ST_HOLD : ST_FETCH_SP;
            end
            ST_FETCH_SP: begin
                fl_req  = 1'b1;
                fl_addr = STACK_ADDR;
                if (fl_valid) nxt = ST_HOLD;
            end
            ST_HOLD: nxt = ST_HOLD;
            default: nxt = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_SETTLE;
            settle_cnt <= '0;
            res_q      <= '0;
            done_q     <= 1'b0;
        end else begin
            state  <= nxt;
            done_q <= 1'b0;
            unique case (state)
                ST_SETTLE: settle_cnt <= settle_cnt + CNT_W'(1);
                ST_DECIDE: begin
                    if (!cfg.bypass && pin_match) begin
                        res_q.rom <= 1'b1;
                        done_q    <= 1'b1;
                    end
                end
                ST_FETCH_PC: begin
                    if (fl_valid) begin
                        if (blank) begin
                            res_q.rom <= 1'b1;
                            done_q    <= 1'b1;
                        end else begin
                            res_q.pc <= fl_rdata;
                        end
                    end
                end
                ST_FETCH_SP: begin
                    if (fl_valid) begin
                        res_q.sp <= fl_rdata;
                        done_q   <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign result = res_q;
    assign done   = done_q;
endmodule

// File: rtl/boot_src_sel.sv
module boot_src_sel
    import boot_sel_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_bypass,
    input  logic [BANK_W-1:0] cfg_bank,
    input  logic [BIT_W-1:0]  cfg_bit,
    input  logic              cfg_level,
    input  logic [GPIO_W-1:0] gpio_in,
    output logic              fl_req,
    output logic [WORD_W-1:0] fl_addr,
    input  logic              fl_valid,
    input  logic [WORD_W-1:0] fl_rdata,
    output logic              rom_map,
    output logic [WORD_W-1:0] init_sp,
    output logic [WORD_W-1:0] init_pc,
    output logic              boot_done
);
    strap_cfg_t        cfg;
    logic [GPIO_W-1:0] gpio_s;
    logic              pin_match;
    boot_result_t      result;

    assign cfg = '{bypass: cfg_bypass, bank: cfg_bank, bit_sel: cfg_bit, level: cfg_level};

    boot_gpio_sync #(.WIDTH(GPIO_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk (clk),
        .rst (rst),
        .d   (gpio_in),
        .q   (gpio_s)
    );

    boot_pin_match i_match (
        .gpio_sync (gpio_s),
        .cfg       (cfg),
        .match     (pin_match)
    );

    boot_fsm i_fsm (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg),
        .pin_match (pin_match),
        .fl_req    (fl_req),
        .fl_addr   (fl_addr),
        .fl_valid  (fl_valid),
        .fl_rdata  (fl_rdata),
        .result    (result),
        .done      (boot_done)
    );

    assign rom_map = result.rom;
    assign init_sp = result.sp;
    assign init_pc = result.pc;
endmodule

// File: rtl/boot_src_sel_chk.sv
module boot_src_sel_chk
    import boot_sel_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              fl_req,
    input logic [WORD_W-1:0] fl_addr,
    input logic              fl_valid,
    input logic              rom_map,
    input logic [WORD_W-1:0] init_sp,
    input logic [WORD_W-1:0] init_pc,
    input logic              boot_done
);
    logic finished;

    always_ff @(posedge clk) begin
        if (rst)            finished <= 1'b0;
        else if (boot_done) finished <= 1'b1;
    end

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!boot_done && !fl_req && !rom_map && init_sp == '0 && init_pc == '0)); // R1
    AST_ROM_ZERO: assert property (@(posedge clk) disable iff (rst)
        (boot_done && rom_map) |-> (init_sp == '0 && init_pc == '0)); // R2
    AST_APP_NOT_BLANK: assert property (@(posedge clk) disable iff (rst)
        (boot_done && !rom_map) |-> (init_pc != BLANK_WORD)); // R6
    AST_ADDR_LEGAL: assert property (@(posedge clk) disable iff (rst)
        fl_req |-> (fl_addr == VECTOR_ADDR || fl_addr == STACK_ADDR)); // R7
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (fl_req && !fl_valid) |=> (fl_req && $stable(fl_addr))); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        boot_done |=> !boot_done); // R9
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        finished |-> ($stable(rom_map) && $stable(init_sp) && $stable(init_pc) && !fl_req && !boot_done)); // R9
endmodule

bind boot_src_sel boot_src_sel_chk i_chk (.*);

// File: tb/test_boot_src_sel.sv
module test_boot_src_sel;
    import boot_sel_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_bypass = 1'b0;
    logic [BANK_W-1:0] cfg_bank = '0;
    logic [BIT_W-1:0]  cfg_bit = '0;
    logic              cfg_level = 1'b0;
    logic [GPIO_W-1:0] gpio_in = '0;
    logic              fl_req;
    logic [WORD_W-1:0] fl_addr;
    logic              fl_valid = 1'b0;
    logic [WORD_W-1:0] fl_rdata = '0;
    logic              rom_map;
    logic [WORD_W-1:0] init_sp;
    logic [WORD_W-1:0] init_pc;
    logic              boot_done;

    always #2 clk = ~clk;

    boot_src_sel i_boot_src_sel (.*);

    typedef struct {
        logic              rom;
        logic [WORD_W-1:0] sp;
        logic [WORD_W-1:0] pc;
        int                reads;
        int                lat;
    } exp_t;

    exp_t              exp_q[$];
    logic [WORD_W-1:0] rd_log[$];
    int                checks = 0;
    int                fails = 0;
    int                cyc = 0;
    int                delay = 0;
    int                wait_cnt = 0;
    int                done_cnt = 0;
    logic [WORD_W-1:0] mem_w0 = '0;
    logic [WORD_W-1:0] mem_w4 = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // flash responder: one-cycle valid after a chosen wait
    initial begin
        forever begin
            @(negedge clk);
            if (fl_valid) begin
                fl_valid = 1'b0;
            end else if (fl_req) begin
                if (wait_cnt >= delay) begin
                    fl_valid = 1'b1;
                    fl_rdata = (fl_addr == VECTOR_ADDR) ? mem_w4 : mem_w0;
                    rd_log.push_back(fl_addr);
                    wait_cnt = 0;
                end else begin
                    wait_cnt++;
                end
            end
        end
    end

    // monitor: pops the expected decision on each done strobe
    initial begin
        forever begin
            @(negedge clk);
            if (rst) cyc = 0;
            else begin
                cyc++;
                if (boot_done) begin
                    done_cnt++;
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R9", "unexpected done", 64'(done_cnt), 64'(0));
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        chk(rom_map == e.rom, "R2/R6/R7", "rom_map", 64'(rom_map), 64'(e.rom));
                        chk(init_sp == e.sp, "R7", "init_sp", 64'(init_sp), 64'(e.sp));
                        chk(init_pc == e.pc, "R7", "init_pc", 64'(init_pc), 64'(e.pc));
                        chk(rd_log.size() == e.reads, "R2/R6/R7", "read count",
                            64'(rd_log.size()), 64'(e.reads));
                        if (rd_log.size() >= 1)
                            chk(rd_log[0] == VECTOR_ADDR, "R4/R5", "first read addr",
                                64'(rd_log[0]), 64'(VECTOR_ADDR));
                        if (rd_log.size() >= 2)
                            chk(rd_log[1] == STACK_ADDR, "R7", "second read addr",
                                64'(rd_log[1]), 64'(STACK_ADDR));
                        if (e.lat >= 0)
                            chk(cyc == e.lat, "R10", "done latency", 64'(cyc), 64'(e.lat));
                    end
                end
            end
        end
    end

    task automatic run_case(input logic byp, input int bank, input int bsel, input logic lvl,
                            input logic [GPIO_W-1:0] gpio, input logic [WORD_W-1:0] w0,
                            input logic [WORD_W-1:0] w4, input int dly);
        exp_t              e;
        int                idx;
        logic              pin_rom;
        int                start_done;
        logic              r_rom;
        logic [WORD_W-1:0] r_sp, r_pc;
        idx     = bank * PINS_PER_BANK + bsel;
        pin_rom = !byp && (gpio[idx] == lvl);
        if (pin_rom) begin
            e = '{rom: 1'b1, sp: '0, pc: '0, reads: 0, lat: 3};
        end else if (w4 == BLANK_WORD) begin
            e = '{rom: 1'b1, sp: '0, pc: '0, reads: 1, lat: -1};
        end else begin
            e = '{rom: 1'b0, sp: w0, pc: w4, reads: 2, lat: -1};
        end
        @(negedge clk);
        rst        = 1'b1;
        cfg_bypass = byp;
        cfg_bank   = BANK_W'(bank);
        cfg_bit    = BIT_W'(bsel);
        cfg_level  = lvl;
        gpio_in    = gpio;
        mem_w0     = w0;
        mem_w4     = w4;
        delay      = dly;
        wait_cnt   = 0;
        repeat (2) @(negedge clk);
        // R1: outputs cleared while reset is held
        chk(!boot_done && !fl_req, "R1", "done/req in reset", 64'({boot_done, fl_req}), 64'(0));
        chk(!rom_map && init_sp == '0 && init_pc == '0, "R1", "results in reset",
            64'(init_pc), 64'(0));
        rd_log.delete();
        exp_q.push_back(e);
        start_done = done_cnt;
        #1 rst = 1'b0;
        for (int i = 0; i < 200 && done_cnt == start_done; i++) @(negedge clk);
        chk(done_cnt == start_done + 1, "R9", "done seen", 64'(done_cnt - start_done), 64'(1));
        // R9: later GPIO changes and time leave the decision untouched
        r_rom   = rom_map;
        r_sp    = init_sp;
        r_pc    = init_pc;
        gpio_in = ~gpio;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(!boot_done && !fl_req, "R9", "quiet after done", 64'({boot_done, fl_req}), 64'(0));
            chk(rom_map == r_rom && init_sp == r_sp && init_pc == r_pc, "R9", "held pc",
                64'(init_pc), 64'(r_pc));
        end
    endtask

    initial begin
        // R2 R10: pin 0 high requests ROM
        run_case(1'b0, 0, 0, 1'b1, 64'h1, 32'h2000_0400, 32'h0000_0101, 0);
        // R3: last pin low while every other line is high
        run_case(1'b0, 7, 7, 1'b0, ~(64'h1 << 63), 32'h1, 32'h2, 0);
        // R3 R5 R7: only the selected pin disagrees, others agree
        run_case(1'b0, 3, 5, 1'b1, ~(64'h1 << 29), 32'h2000_8000, 32'h0000_1235, 2);
        // R4 R6: bypass with a matching pin, blank vector
        run_case(1'b1, 1, 2, 1'b1, {GPIO_W{1'b1}}, 32'h2000_0000, 32'hFFFF_FFFF, 1);
        // R4 R7: bypass, application present, zero wait
        run_case(1'b1, 4, 4, 1'b0, '0, 32'h2003_FFF0, 32'h0000_0241, 0);
        // R5 R8: mismatch, long flash wait
        run_case(1'b0, 6, 1, 1'b0, 64'h0002_0000_0000_0000, 32'h1234_5678, 32'h8765_4321, 5);
        // R6 R8: mismatch, blank vector after a wait
        run_case(1'b0, 5, 3, 1'b1, '0, 32'h0, 32'hFFFF_FFFF, 3);
        // R3: bank 2 pin 0 low matches, neighbour high
        run_case(1'b0, 2, 0, 1'b0, 64'h0000_0000_0002_0000, 32'h5, 32'h6, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule